// File: doc/BRIEF.md
# CHERI Trap Value CSR Unit

This unit records diagnostic data when a trap is taken and keeps it in four trap value registers: a machine-level trap value and second trap value, and a supervisor-level pair with the same roles. When the trap comes from a capability fault, the first register of the destination mode gets a packed word. That word holds a fault type, a cause code and the number of the capability register that raised the fault. The second register of that mode gets the faulting data address, or zero when the fault came from the program counter capability.

When several capability violations are flagged together, a fixed priority encoder chooses the single cause that is reported. Traps that are not capability faults load the standard trap values instead. A trap only writes the registers of its destination mode; the registers of the other mode keep their contents.

Software reads and writes all four registers through a simple single-cycle CSR port. The read data is combinational from the address. A trap in the same cycle as a CSR write wins over the write.

Top module: `cheri_tval_unit`

## Requirements
- R1: After reset, all four registers read as zero.
- R2: A capability-fault trap writes a packed word to the first register of its destination mode. The cause is in bits 3:0, the faulting register index is in bits 9:4, the fault type is in bits 19:16, and every other bit is zero. Any index 0 to 63 is stored unchanged: 0 to 31 are c0 to c31, 32 is the default data capability and 33 is the program counter capability.
- R3: The violation flag vector decides the cause. Bit 0 is a bounds violation and bit 1 is an invalid-address violation; higher bits have higher priority. The cause code is the index of the highest set flag plus one, so a bounds violation (code 1) is reported only when no other flag is set. When no flag is set, the cause input is used unchanged.
- R4: On a capability-fault trap to M-mode, the machine second trap value is set to the faulting address for a data memory access. For a program counter capability fault it is set to zero.
- R5: On a trap that is not a capability fault, the first register of the destination mode is loaded from the standard trap value input. An M-mode trap of this kind also loads the machine second trap value from the standard second trap value input.
- R6: On a trap to S-mode, the supervisor second trap value is set to the faulting address for a capability-fault data memory access, and to zero in every other case.
- R7: A trap leaves both registers of the other privilege mode unchanged.
- R8: The CSR addresses are 0x343 (machine trap value), 0x34B (machine second trap value), 0x143 (supervisor trap value) and 0x14B (supervisor second trap value). A write to any of them lands on the next clock edge. Any other address reads as zero, and a write to it changes no register.
- R9: A CSR write in the same cycle as a trap is discarded, whatever address it targets; the trap writes happen as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_vld | input | 1 | A trap is taken this cycle |
| trap_to_s | input | 1 | Destination mode: 1 = S-mode, 0 = M-mode |
| trap_cheri | input | 1 | The trap is a capability fault |
| trap_mem | input | 1 | Capability fault on a data memory access (0 = program counter capability fault) |
| trap_type | input | 4 | Capability fault type |
| trap_cause | input | 4 | Cause code used when no violation flag is set |
| trap_cap_idx | input | 6 | Index of the faulting capability register |
| trap_addr | input | XLEN | Faulting data address |
| trap_viol | input | NUM_VIOL | Simultaneous violation flags, higher index has higher priority |
| std_tval | input | XLEN | Standard trap value for traps that are not capability faults |
| std_tval2 | input | XLEN | Standard second trap value for M-mode traps that are not capability faults |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, combinational from csr_addr |

## Verification
A trap and a CSR write can happen in the same cycle. The bench provokes this by raising a write strobe during trap cycles. Some of those writes target the register that the trap loads. Others target a register of the other privilege mode, which the trap does not touch. Afterwards, all four registers are read back through the port, and every one must hold the value from the trap or its earlier value, never the write data.

// File: rtl/cheri_tval_pkg.sv
package cheri_tval_pkg;
  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned CAUSE_W = 4;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned TYPE_W  = 4;
  localparam int unsigned CAUSE_LSB = 0;
  localparam int unsigned IDX_LSB   = 4;
  localparam int unsigned TYPE_LSB  = 16;

  localparam logic [CSR_AW-1:0] CSR_STVAL  = 12'h143;
  localparam logic [CSR_AW-1:0] CSR_STVAL2 = 12'h14B;
  localparam logic [CSR_AW-1:0] CSR_MTVAL  = 12'h343;
  localparam logic [CSR_AW-1:0] CSR_MTVAL2 = 12'h34B;

  localparam logic [CAUSE_W-1:0] CAUSE_BOUNDS = 4'd1;

  typedef struct packed {
    logic [TYPE_W-1:0]  ftype;
    logic [IDX_W-1:0]   idx;
    logic [CAUSE_W-1:0] cause;
  } fault_info_t;
endpackage

// File: rtl/cheri_cause_prio.sv
module cheri_cause_prio
  import cheri_tval_pkg::*;
#(
  parameter int unsigned NUM_VIOL = 4
) (
  input  logic [NUM_VIOL-1:0] viol,
  input  logic [CAUSE_W-1:0]  dflt_cause,
  output logic [CAUSE_W-1:0]  cause
);
  always_comb begin
    cause = dflt_cause;
    for (int i = 0; i < NUM_VIOL; i++) begin
      if (viol[i]) cause = CAUSE_W'(i + 1);
    end
  end

  generate
    if (NUM_VIOL > 1) begin : g_prio_chk
      always_comb begin
        if (viol[1]) begin
          // R3
          bounds_masked_chk: assert (cause != CAUSE_BOUNDS);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cheri_tval_pack.sv
module cheri_tval_pack
  import cheri_tval_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  fault_info_t     info,
  output logic [XLEN-1:0] word
);
  always_comb begin
    word = '0;
    word[CAUSE_LSB +: CAUSE_W] = info.cause;
    word[IDX_LSB   +: IDX_W]   = info.idx;
    word[TYPE_LSB  +: TYPE_W]  = info.ftype;
  end
endmodule

// File: rtl/cheri_tval_bank.sv
module cheri_tval_bank
  import cheri_tval_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_vld,
  input  logic              trap_to_s,
  input  logic              trap_cheri,
  input  logic              trap_mem,
  input  logic [XLEN-1:0]   cheri_word,
  input  logic [XLEN-1:0]   trap_addr,
  input  logic [XLEN-1:0]   std_tval,
  input  logic [XLEN-1:0]   std_tval2,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata
);
  logic [XLEN-1:0] mtval_q, mtval2_q, stval_q, stval2_q;
  logic [XLEN-1:0] nxt_tval, nxt_m2, nxt_s2;

  always_comb begin
    nxt_tval = trap_cheri ? cheri_word : std_tval;
    nxt_m2   = trap_cheri ? (trap_mem ? trap_addr : '0) : std_tval2;
    nxt_s2   = (trap_cheri && trap_mem) ? trap_addr : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mtval_q  <= '0;
      mtval2_q <= '0;
      stval_q  <= '0;
      stval2_q <= '0;
    end else if (trap_vld) begin
      if (trap_to_s) begin
        stval_q  <= nxt_tval;
        stval2_q <= nxt_s2;
      end else begin
        mtval_q  <= nxt_tval;
        mtval2_q <= nxt_m2;
      end
    end else if (csr_we) begin
      case (csr_addr)
        CSR_MTVAL:  mtval_q  <= csr_wdata;
        CSR_MTVAL2: mtval2_q <= csr_wdata;
        CSR_STVAL:  stval_q  <= csr_wdata;
        CSR_STVAL2: stval2_q <= csr_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (csr_addr)
      CSR_MTVAL:  csr_rdata = mtval_q;
      CSR_MTVAL2: csr_rdata = mtval2_q;
      CSR_STVAL:  csr_rdata = stval_q;
      CSR_STVAL2: csr_rdata = stval2_q;
      default:    csr_rdata = '0;
    endcase
  end

  // R7
  m_hold_on_s_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && trap_to_s) |=> (mtval_q == $past(mtval_q) && mtval2_q == $past(mtval2_q)));

  // R4
  pcc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !trap_to_s && trap_cheri && !trap_mem) |=> (mtval2_q == '0));

  // R6
  s_tval2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && trap_to_s && !(trap_cheri && trap_mem)) |=> (stval2_q == '0));

  // R9
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !trap_to_s && csr_we && csr_addr == CSR_STVAL) |=> (stval_q == $past(stval_q)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && !trap_to_s && trap_cheri) |=> (mtval_q[15:10] == '0));
endmodule

// File: rtl/cheri_tval_unit.sv
module cheri_tval_unit
  import cheri_tval_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NUM_VIOL = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_vld,
  input  logic                trap_to_s,
  input  logic                trap_cheri,
  input  logic                trap_mem,
  input  logic [3:0]          trap_type,
  input  logic [3:0]          trap_cause,
  input  logic [5:0]          trap_cap_idx,
  input  logic [XLEN-1:0]     trap_addr,
  input  logic [NUM_VIOL-1:0] trap_viol,
  input  logic [XLEN-1:0]     std_tval,
  input  logic [XLEN-1:0]     std_tval2,
  input  logic                csr_we,
  input  logic [11:0]         csr_addr,
  input  logic [XLEN-1:0]     csr_wdata,
  output logic [XLEN-1:0]     csr_rdata
);
  fault_info_t        info;
  logic [CAUSE_W-1:0] sel_cause;
  logic [XLEN-1:0]    cheri_word;

  cheri_cause_prio #(.NUM_VIOL(NUM_VIOL)) u_prio (
    .viol       (trap_viol),
    .dflt_cause (trap_cause),
    .cause      (sel_cause)
  );

  assign info = '{ftype: trap_type, idx: trap_cap_idx, cause: sel_cause};

  cheri_tval_pack #(.XLEN(XLEN)) u_pack (
    .info (info),
    .word (cheri_word)
  );

  cheri_tval_bank #(.XLEN(XLEN)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_vld   (trap_vld),
    .trap_to_s  (trap_to_s),
    .trap_cheri (trap_cheri),
    .trap_mem   (trap_mem),
    .cheri_word (cheri_word),
    .trap_addr  (trap_addr),
    .std_tval   (std_tval),
    .std_tval2  (std_tval2),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata)
  );
endmodule

// File: tb/test_cheri_tval_unit.sv
`timescale 1ns/1ps
module test_cheri_tval_unit;
  localparam int XLEN = 64;
  localparam int NV   = 4;
  localparam logic [11:0] A_MT = 12'h343, A_MT2 = 12'h34B, A_ST = 12'h143, A_ST2 = 12'h14B;

  logic clk = 0, rst_n = 0;
  logic trap_vld = 0, trap_to_s = 0, trap_cheri = 0, trap_mem = 0;
  logic [3:0] trap_type = 0, trap_cause = 0;
  logic [5:0] trap_cap_idx = 0;
  logic [XLEN-1:0] trap_addr = 0, std_tval = 0, std_tval2 = 0, csr_wdata = 0;
  logic [NV-1:0] trap_viol = 0;
  logic csr_we = 0;
  logic [11:0] csr_addr = 0;
  logic [XLEN-1:0] csr_rdata;

  int n_vec = 0, n_bad = 0;
  logic [XLEN-1:0] m_mt = 0, m_mt2 = 0, m_st = 0, m_st2 = 0;

  always #2 clk = ~clk;

  cheri_tval_unit #(.XLEN(XLEN), .NUM_VIOL(NV)) i_cheri_tval_unit (.*);

  function automatic logic [3:0] exp_cause(logic [NV-1:0] v, logic [3:0] d);
    logic [3:0] c = d;
    for (int i = 0; i < NV; i++) if (v[i]) c = 4'(i + 1);
    return c;
  endfunction

  function automatic logic [XLEN-1:0] exp_word(logic [3:0] t, logic [3:0] c, logic [5:0] x);
    return (XLEN'(t) << 16) | (XLEN'(x) << 4) | XLEN'(c);
  endfunction

  task automatic chk(string req, logic [11:0] a, logic [XLEN-1:0] exp);
    csr_addr = a;
    #1;
    n_vec++;
    if (csr_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, a, csr_rdata, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, A_MT, m_mt);
    chk(req, A_MT2, m_mt2);
    chk(req, A_ST, m_st);
    chk(req, A_ST2, m_st2);
  endtask

  // one trap, optionally with a colliding CSR write (discarded, R9)
  task automatic do_trap(logic s, logic ch, logic mem, logic [NV-1:0] v, logic [3:0] t,
                         logic [3:0] c, logic [5:0] x, logic [XLEN-1:0] ad,
                         logic [XLEN-1:0] st, logic [XLEN-1:0] st2,
                         logic we, logic [11:0] wa, logic [XLEN-1:0] wd);
    logic [XLEN-1:0] tv;
    @(negedge clk);
    trap_vld = 1; trap_to_s = s; trap_cheri = ch; trap_mem = mem; trap_viol = v;
    trap_type = t; trap_cause = c; trap_cap_idx = x; trap_addr = ad;
    std_tval = st; std_tval2 = st2; csr_we = we; csr_addr = wa; csr_wdata = wd;
    @(negedge clk);
    trap_vld = 0; csr_we = 0;
    tv = ch ? exp_word(t, exp_cause(v, c), x) : st;
    if (s) begin
      m_st = tv; m_st2 = (ch && mem) ? ad : '0;
    end else begin
      m_mt = tv; m_mt2 = ch ? (mem ? ad : '0) : st2;
    end
  endtask

  task automatic csr_write(logic [11:0] a, logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
    case (a)
      A_MT: m_mt = d;  A_MT2: m_mt2 = d;
      A_ST: m_st = d;  A_ST2: m_st2 = d;
      default: ;
    endcase
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1 reset");

    // sweep: mode x kind x origin x all violation patterns (R2..R7)
    for (int s = 0; s < 2; s++)
      for (int ch = 0; ch < 2; ch++)
        for (int mem = 0; mem < 2; mem++)
          for (int v = 0; v < 16; v++) begin
            n++;
            do_trap(s[0], ch[0], mem[0], v[NV-1:0], 4'(n * 3), 4'(n * 5 + 2), 6'(n * 7 + 32),
                    {32'hA5A5_0000 + 32'(n), 32'(n * 977)},
                    {32'h5100_0000 + 32'(n), 32'h0BAD_0000},
                    {32'h7200_0000 + 32'(n), 32'h0CAB_0000}, 1'b0, 12'h0, '0);
            chk_all("R2/R3/R4/R5/R6/R7 sweep");
          end

    // cap index extremes: DDC and PCC codes stored as given (R2)
    do_trap(1'b0, 1'b1, 1'b1, 4'b0, 4'hF, 4'h9, 6'd33, 64'hFFFF_0000_1234_5678, '0, '0, 1'b0, 12'h0, '0);
    chk("R2 pcc idx", A_MT, 64'h000F_0219);
    do_trap(1'b1, 1'b1, 1'b0, 4'b0011, 4'h2, 4'h0, 6'd32, 64'h1, '0, '0, 1'b0, 12'h0, '0);
    chk("R3 invalid-address over bounds", A_ST, 64'h0002_0202);
    chk("R6 pcc fault to S", A_ST2, 64'h0);

    // CSR port (R8)
    csr_write(A_MT,  64'h1111_2222_3333_4444);
    csr_write(A_MT2, 64'h5555_6666_7777_8888);
    csr_write(A_ST,  64'h9999_AAAA_BBBB_CCCC);
    csr_write(A_ST2, 64'hDDDD_EEEE_FFFF_0001);
    chk_all("R8 write/read");
    csr_write(12'h340, 64'hDEAD_BEEF_DEAD_BEEF);
    chk("R8 unmapped reads zero", 12'h340, 64'h0);
    chk_all("R8 unmapped write ignored");

    // trap collides with CSR write (R9)
    do_trap(1'b0, 1'b1, 1'b1, 4'b0001, 4'h3, 4'h0, 6'd5, 64'hCAFE, '0, '0, 1'b1, A_MT, 64'h1234);
    chk_all("R9 write to trapped register");
    do_trap(1'b0, 1'b0, 1'b0, 4'b0, 4'h0, 4'h0, 6'd0, '0, 64'h77, 64'h88, 1'b1, A_ST, 64'h4321);
    chk_all("R9 write to other mode register");
    do_trap(1'b1, 1'b1, 1'b1, 4'b1000, 4'h1, 4'h0, 6'd63, 64'hBEEF, '0, '0, 1'b1, A_MT2, 64'h99);
    chk_all("R9 S trap vs M write");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule